// File: doc/BRIEF.md
# Per-Select SPI Clock and Character Framer

This block drives the serial side of an SPI controller for one transaction at a time. A bank holds one 32-bit mode word per chip select. A start strobe latches the mode word of the chosen select together with the first parallel character. The block then asserts that select, waits a programmable setup time, and shifts the character out on `mosi` while it samples `miso`. Between characters it inserts a programmable gap. After the last character it waits a programmable hold time and releases the select.

Every phase is counted in serial-clock half-periods. A half-period lasts 2·(PM+1) system cycles, and a mode bit multiplies that by 16. The serial period therefore runs from 4 to 1024 system cycles.

At the end of each character the block reports the received bits with a one-cycle `rx_valid` pulse. In the same cycle it samples `tx_more` to decide whether another character follows. If one does, it takes that character from `tx_char`.

Top module: `spi_char_framer`

## Requirements
- R1: Each select owns a mode word. The word is written from `cfg_word` when `cfg_we` is high, at index `cfg_sel`. After reset every word equals 32'h0010_0008: select active low, character gap 1, all other fields 0.
- R2: One half-period lasts 2·(PM+1) system cycles, where PM is bits 27:24. When bit 28 is set it lasts 16 times as long. A full serial period is therefore 4·(PM+1) or 64·(PM+1) system cycles.
- R3: Bit 31 gives the idle level of `sck`. `sck` holds that level while idle and during setup, gap and hold.
- R4: Bit 30 selects the clock phase. With 0, each bit occupies two half-periods: in the first `sck` is idle, in the second it is active, and `miso` is sampled at the leading edge. With 1, the first half-period is active and the second idle, and `miso` is sampled at the trailing edge.
- R5: Bits 19:16 hold the character length minus one, giving 4 to 16 bits. Field values 0 to 2 are treated as a length of 4.
- R6: Bit 29 requests MSB-first order. It is honoured only for 8-bit and 16-bit characters; every other length is shifted LSB-first. Each received bit is stored at the position that the transmitted bit of the same slot came from. Bits of `rx_char` at and above the length read 0.
- R7: When bit 20 is 1 the select is active low; when it is 0 the select is active high. While busy, only the started select is active. Every other select, and every select while idle, sits at its inactive level.
- R8: After the start strobe the select is active for bits 15:12 half-periods before the first bit. After the last character it stays active for bits 11:8 half-periods, then it is released.
- R9: At the end of each character `tx_more` and `tx_char` are sampled. If `tx_more` is 1, the next character follows after a gap of bits 7:3 half-periods with the select still active. A gap of 0 means back-to-back characters.
- R10: A start strobe while busy is ignored. A mode write during a transaction does not change that transaction; it takes effect at the next start.
- R11: `rx_valid` is high for exactly one cycle: the cycle after the last half-period of each character. In that cycle `rx_char` shows the character that was received.
- R12: `mosi` is 0 whenever no bit is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_sel | input | SEL_W | Select whose mode word is written |
| cfg_word | input | 32 | Mode word data |
| start | input | 1 | Transaction start strobe |
| start_sel | input | SEL_W | Select to use for the transaction |
| tx_char | input | 16 | Character to send (right-aligned) |
| tx_more | input | 1 | Another character follows (sampled at character end) |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_o | output | NCS | Chip selects, level set per select |
| busy | output | 1 | Transaction in progress |
| rx_char | output | 16 | Last received character |
| rx_valid | output | 1 | One-cycle pulse with a new `rx_char` |

## Verification
Two functions can fall in the same cycle, and the bench aims at both. First, with a zero gap the end of one character meets the start of the next in a single edge. That edge captures the received word, raises `rx_valid`, loads the next character and restarts the shift slots. A three-character run with gap 0 provokes this, and a cycle-exact reference model judges it by checking `rx_char`, `mosi` and `sck` on every clock. Second, a start strobe and a mode write for the active select arrive together in the middle of a transaction. The bench checks that the waveform keeps following the latched mode, and that the following transaction uses the newly written word.

// File: rtl/spi_fr_pkg.sv
package spi_fr_pkg;

    localparam int CHAR_W = 16;
    localparam int WORD_W = 32;
    localparam int SLOT_W = 5;
    localparam int HALF_W = 10;
    localparam logic [WORD_W-1:0] MODE_RST_WORD = 32'h0010_0008;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_GAP,
        ST_HOLD
    } fr_state_e;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       msb;
        logic       div16;
        logic [3:0] pm;
        logic       cs_low;
        logic [3:0] len_m1;
        logic [3:0] setup;
        logic [3:0] hold;
        logic [4:0] gap;
    } mode_t;

    function automatic mode_t unpack_mode(input logic [WORD_W-1:0] w);
        mode_t m;
        m.cpol   = w[31];
        m.cpha   = w[30];
        m.msb    = w[29];
        m.div16  = w[28];
        m.pm     = w[27:24];
        m.cs_low = w[20];
        m.len_m1 = w[19:16];
        m.setup  = w[15:12];
        m.hold   = w[11:8];
        m.gap    = w[7:3];
        return m;
    endfunction

    // index of the last bit of a character (length - 1), clamped to 3
    function automatic logic [3:0] char_last(input mode_t m);
        return (m.len_m1 < 4'd3) ? 4'd3 : m.len_m1;
    endfunction

    function automatic logic msb_first(input mode_t m);
        logic [3:0] l;
        l = char_last(m);
        return m.msb && (l == 4'd7 || l == 4'd15);
    endfunction

    // system cycles per serial half-period
    function automatic logic [HALF_W-1:0] half_len(input mode_t m);
        logic [HALF_W-1:0] h;
        h = ({{(HALF_W-4){1'b0}}, m.pm} + HALF_W'(1)) << 1;
        if (m.div16) h = h << 4;
        return h;
    endfunction

endpackage

// File: rtl/spi_fr_modebank.sv
module spi_fr_modebank
    import spi_fr_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int SEL_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [SEL_W-1:0]          sel,
    input  logic [WORD_W-1:0]         wdata,
    output mode_t [NCS-1:0]           words_o
);

    mode_t [NCS-1:0] words_d, words_q;

    always_comb begin
        words_d = words_q;
        if (we) words_d[sel] = unpack_mode(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCS; i++) words_q[i] <= unpack_mode(MODE_RST_WORD);
        end else begin
            words_q <= words_d;
        end
    end

    assign words_o = words_q;

endmodule

// File: rtl/spi_fr_halftimer.sv
module spi_fr_halftimer
    import spi_fr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HALF_W-1:0] half_cycles,
    output logic              tick
);

    logic [HALF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == half_cycles - HALF_W'(1));
        cnt_d = (!en || tick) ? '0 : cnt_q + HALF_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_char_framer.sv
module spi_char_framer
    import spi_fr_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [WORD_W-1:0]  cfg_word,
    input  logic               start,
    input  logic [SEL_W-1:0]   start_sel,
    input  logic [CHAR_W-1:0]  tx_char,
    input  logic               tx_more,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic [NCS-1:0]     cs_o,
    output logic               busy,
    output logic [CHAR_W-1:0]  rx_char,
    output logic               rx_valid
);

    typedef struct packed {
        fr_state_e          state;
        logic [SLOT_W-1:0]  slot;
        mode_t              mode;
        logic [SEL_W-1:0]   sel;
        logic [CHAR_W-1:0]  tx;
        logic [CHAR_W-1:0]  acc;
        logic [CHAR_W-1:0]  rx;
        logic               rxv;
    } regs_t;

    regs_t d, q;
    mode_t [NCS-1:0] bank;
    logic tick;

    logic [3:0] last_idx, bit_k, pos;
    logic       msb_eff, in_shift;

    spi_fr_modebank #(.NCS(NCS), .SEL_W(SEL_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_word),
        .words_o (bank)
    );

    spi_fr_halftimer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (q.state != ST_IDLE),
        .half_cycles (half_len(q.mode)),
        .tick        (tick)
    );

    always_comb begin
        last_idx = char_last(q.mode);
        msb_eff  = msb_first(q.mode);
        bit_k    = q.slot[4:1];
        pos      = msb_eff ? (last_idx - bit_k) : bit_k;
        in_shift = (q.state == ST_SHIFT);
    end

    always_comb begin
        d     = q;
        d.rxv = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.mode  = bank[start_sel];
                    d.sel   = start_sel;
                    d.tx    = tx_char;
                    d.acc   = '0;
                    d.slot  = '0;
                    d.state = (bank[start_sel].setup == 4'd0) ? ST_SHIFT : ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    if (({1'b0, q.slot} + 6'd1) == {2'b00, q.mode.setup}) begin
                        d.slot  = '0;
                        d.state = ST_SHIFT;
                    end else begin
                        d.slot = q.slot + SLOT_W'(1);
                    end
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.slot[0]) d.acc[pos] = miso;
                    if (q.slot == {last_idx, 1'b1}) begin
                        d.rxv  = 1'b1;
                        d.rx   = q.acc;
                        d.slot = '0;
                        if (tx_more) begin
                            d.tx    = tx_char;
                            d.acc   = '0;
                            d.state = (q.mode.gap == 5'd0) ? ST_SHIFT : ST_GAP;
                        end else begin
                            d.state = (q.mode.hold == 4'd0) ? ST_IDLE : ST_HOLD;
                        end
                    end else begin
                        d.slot = q.slot + SLOT_W'(1);
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (({1'b0, q.slot} + 6'd1) == {1'b0, q.mode.gap}) begin
                        d.slot  = '0;
                        d.state = ST_SHIFT;
                    end else begin
                        d.slot = q.slot + SLOT_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (({1'b0, q.slot} + 6'd1) == {2'b00, q.mode.hold}) begin
                        d.slot  = '0;
                        d.state = ST_IDLE;
                    end else begin
                        d.slot = q.slot + SLOT_W'(1);
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.mode  <= unpack_mode(MODE_RST_WORD);
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.state != ST_IDLE);
    assign sck      = in_shift ? (q.mode.cpol ^ (q.slot[0] ^ q.mode.cpha)) : q.mode.cpol;
    assign mosi     = in_shift ? q.tx[pos] : 1'b0;
    assign rx_char  = q.rx;
    assign rx_valid = q.rxv;

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_o[i] = (busy && q.sel == SEL_W'(i)) ? ~q.mode.cs_low : bank[i].cs_low;
    end

endmodule

// File: rtl/spi_fr_checker.sv
module spi_fr_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sck,
    input logic mosi,
    input logic rx_valid
);

    // R12: no data driven outside a transaction
    p_idle_mosi_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    // R3: clock level is frozen while idle
    p_idle_sck_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(sck));

    // R2: a half-period is never shorter than two system cycles
    p_sck_min_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != $past(sck)) |=> $stable(sck));

    // R11: result strobe lasts a single cycle
    p_rxv_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11: a result only follows an active transaction
    p_rxv_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(busy));

endmodule

bind spi_char_framer spi_fr_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sck      (sck),
    .mosi     (mosi),
    .rx_valid (rx_valid)
);

// File: tb/spi_char_framer_bench.sv
module spi_char_framer_bench;

    localparam int NCS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_word = '0;
    logic        start = 1'b0;
    logic [1:0]  start_sel = '0;
    logic [15:0] tx_char = '0;
    logic        tx_more = 1'b0;
    logic        miso = 1'b0;
    logic        sck, mosi, busy, rx_valid;
    logic [3:0]  cs_o;
    logic [15:0] rx_char;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    spi_char_framer #(.NCS(NCS)) u_spi_char_framer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_word(cfg_word), .start(start), .start_sel(start_sel),
        .tx_char(tx_char), .tx_more(tx_more), .miso(miso), .sck(sck),
        .mosi(mosi), .cs_o(cs_o), .busy(busy), .rx_char(rx_char),
        .rx_valid(rx_valid)
    );

    typedef struct {
        bit        sck, mosi, busy, rxv, miso;
        bit [3:0]  cs;
        bit [15:0] rxc;
    } cyc_t;

    cyc_t      exp_q[$];
    bit [15:0] g_tx[$];
    bit [15:0] g_rx[$];
    bit [31:0] bw[NCS];
    bit [15:0] exp_rx = '0;
    bit        pend = 0;
    bit [15:0] pend_val = '0;

    task automatic push(bit s, bit m, bit b, bit mi, int sel);
        cyc_t e;
        e.sck = s; e.mosi = m; e.busy = b; e.miso = mi;
        for (int j = 0; j < NCS; j++)
            e.cs[j] = (b && j == sel) ? ~bw[j][20] : bw[j][20];
        e.rxv = pend;
        if (pend) exp_rx = pend_val;
        pend = 0;
        e.rxc = exp_rx;
        exp_q.push_back(e);
    endtask

    task automatic build(int sel);
        bit [31:0] m;
        bit cpol, cpha, msb;
        int L, lm, H, bef, aft, gap, n, mask;
        m    = bw[sel];
        cpol = m[31]; cpha = m[30];
        lm   = (m[19:16] < 3) ? 3 : int'(m[19:16]);
        L    = lm + 1;
        msb  = m[29] && (L == 8 || L == 16);
        H    = 2 * (int'(m[27:24]) + 1) * (m[28] ? 16 : 1);
        bef  = m[15:12]; aft = m[11:8]; gap = m[7:3];
        n    = g_tx.size();
        mask = (1 << L) - 1;
        exp_q.delete();
        for (int b = 0; b < bef * H; b++) push(cpol, 0, 1, 0, sel);
        for (int i = 0; i < n; i++) begin
            for (int s = 0; s < 2 * L; s++) begin
                int k;
                bit tb, rb, sv;
                k  = s / 2;
                tb = msb ? g_tx[i][lm - k] : g_tx[i][k];
                rb = msb ? g_rx[i][lm - k] : g_rx[i][k];
                sv = cpol ^ ((s % 2 == 1) ^ cpha);
                for (int h = 0; h < H; h++) push(sv, tb, 1, rb, sel);
            end
            pend = 1;
            pend_val = g_rx[i] & 16'(mask);
            if (i < n - 1) begin
                for (int g = 0; g < gap * H; g++) push(cpol, 0, 1, 0, sel);
            end else begin
                for (int g = 0; g < aft * H; g++) push(cpol, 0, 1, 0, sel);
            end
        end
        for (int z = 0; z < 3; z++) push(cpol, 0, 0, 0, sel);
    endtask

    task automatic wr_mode(int sel, bit [31:0] w);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_word = w;
        @(negedge clk);
        cfg_we = 0;
        bw[sel] = w;
    endtask

    task automatic run(int sel, string tag, bit do_poke, bit [31:0] poke_w);
        int idx;
        int n;
        build(sel);
        n = g_tx.size();
        idx = 0;
        @(negedge clk);
        tx_char = g_tx[0]; start_sel = 2'(sel); start = 1; tx_more = 0;
        for (int c = 0; c < exp_q.size(); c++) begin
            bit [23:0] a, e;
            @(negedge clk);
            if (c == 0) start = 0;
            a = {sck, mosi, busy, rx_valid, cs_o, rx_char};
            e = {exp_q[c].sck, exp_q[c].mosi, exp_q[c].busy, exp_q[c].rxv,
                 exp_q[c].cs, exp_q[c].rxc};
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s cycle %0d {sck,mosi,busy,rxv,cs,rx}: actual=%h expected=%h",
                         tag, c, a, e);
            end
            if (exp_q[c].rxv) idx++;
            tx_char = (idx + 1 < n) ? g_tx[idx + 1] : 16'h0;
            tx_more = (idx + 1 < n);
            miso    = exp_q[c].miso;
            if (do_poke && c == 5) begin
                start = 1; start_sel = 2'((sel + 1) % NCS);
                cfg_we = 1; cfg_sel = 2'(sel); cfg_word = poke_w;
            end
            if (do_poke && c == 6) begin
                start = 0; cfg_we = 0; bw[sel] = poke_w;
            end
        end
        miso = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int j = 0; j < NCS; j++) bw[j] = 32'h0010_0008;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 R3 R7 R12: reset state at the ports
        n_checks++;
        if ({cs_o, sck, mosi, busy, rx_valid, rx_char} !== {4'hF, 4'b0000, 16'h0}) begin
            n_fail++;
            $display("FAIL R1 R3 R7 R12 reset: actual=%h expected=%h",
                     {cs_o, sck, mosi, busy, rx_valid, rx_char}, {4'hF, 4'b0000, 16'h0});
        end

        // R1 R5: default word, length field 0 clamps to 4 bits, LSB first
        g_tx = '{16'h000A}; g_rx = '{16'h0005};
        run(1, "R1 R5 R11 default", 0, 0);

        // R2 R4 R6 R8 R9: phase 0, 8-bit MSB first, setup 2, hold 1, gap 3
        wr_mode(0, (1 << 29) | (1 << 24) | (1 << 20) | (7 << 16) | (2 << 12) | (1 << 8) | (3 << 3));
        g_tx = '{16'h00A5, 16'h003C}; g_rx = '{16'h005A, 16'h00C3};
        run(0, "R2 R4 R6 R8 R9", 0, 0);

        // R3 R4 R6 R7: idle high, phase 1, 16-bit MSB, active-high select
        wr_mode(2, (1 << 31) | (1 << 30) | (1 << 29) | (15 << 16) | (1 << 12) | (2 << 8));
        g_tx = '{16'hBEEF}; g_rx = '{16'h1234};
        run(2, "R3 R4 R6 R7", 0, 0);

        // R6 R9 R11: 12-bit with MSB bit set shifts LSB first, zero gap
        wr_mode(3, (1 << 30) | (1 << 29) | (2 << 24) | (1 << 20) | (11 << 16));
        g_tx = '{16'h09A5, 16'h03C1, 16'h0FFF}; g_rx = '{16'h0123, 16'h0ABC, 16'h0000};
        run(3, "R6 R9 R11 back-to-back", 0, 0);

        // R2 R5: extra divide by 16, 5-bit characters
        wr_mode(0, (1 << 31) | (1 << 28) | (1 << 20) | (4 << 16) | (1 << 12) | (1 << 8) | (2 << 3));
        g_tx = '{16'h0015}; g_rx = '{16'h000A};
        run(0, "R2 R5 div16", 0, 0);

        // R2: slowest clock, PM 15 with divide by 16
        wr_mode(1, (1 << 28) | (15 << 24) | (1 << 20) | (3 << 16));
        g_tx = '{16'h0009}; g_rx = '{16'h0006};
        run(1, "R2 slowest", 0, 0);

        // R10: start and mode write during a transaction do not disturb it
        g_tx = '{16'h1357}; g_rx = '{16'h2468};
        run(2, "R10 busy poke", 1, (7 << 16) | (1 << 3));
        g_tx = '{16'h00C6}; g_rx = '{16'h0071};
        run(2, "R10 R7 new word", 0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule